// File: doc/BRIEF.md
# Inertial Horizontal Motion Controller

This block keeps the horizontal position of a player sprite whose velocity has inertia. The velocity is held as an unsigned speed and a separate direction flag. Two active-low, already debounced push buttons request motion to the left or to the right. Each press is found on the falling edge of the synchronised button level and gives one unit of acceleration toward the requested side. Releasing a button leaves the velocity as it is, so the sprite keeps drifting.

The sprite moves by one velocity step for each frame-tick pulse, which arrives once per video frame. Its position is kept inside a band that leaves a margin at each screen edge and room for the sprite's width. If a step would carry the sprite past either edge of that band, the sprite stops at the edge and its speed is cleared.

Top module: `inertial_motion_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the block loads pos_x = 303 (the middle of the allowed band for the default parameters), speed = 0 and dir_right = 0.
- R2: A button counts as one press when its synchronised level goes from high to low. Holding it low for any length of time gives exactly one press, and releasing it gives none.
- R3: A press toward the current direction (right while dir_right = 1, left while dir_right = 0) raises speed by 1.
- R4: A press against the current direction while speed > 0 lowers speed by 1 and leaves dir_right unchanged.
- R5: A press against the current direction while speed = 0 sets speed to 1 and flips dir_right to the pressed side.
- R6: Speed never exceeds MAX_SPEED (default 7). A press that would raise it further leaves it at MAX_SPEED.
- R7: A left press and a right press recognised in the same cycle cancel each other, so speed and dir_right do not change.
- R8: pos_x changes only on a clock edge where frame_tick is high. On that edge it grows by speed when dir_right = 1 and shrinks by speed when dir_right = 0.
- R9: pos_x stays inside [MARGIN, 639 - MARGIN - SPRITE_W], which is [8, 599] for the defaults. A step that would go past a bound sets pos_x to that bound, sets speed to 0 and keeps dir_right.
- R10: A step that lands exactly on a bound is not a border hit, and speed is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_left_n | input | 1 | Left button level, low while pressed |
| btn_right_n | input | 1 | Right button level, low while pressed |
| frame_tick | input | 1 | One-cycle pulse per frame that advances the position |
| pos_x | output | 10 | Sprite x position |
| speed | output | $clog2(MAX_SPEED+1) | Speed magnitude |
| dir_right | output | 1 | 1 = moving right, 0 = moving left |

## Verification
Speed and direction are visible on the ports. A wrong acceleration, a missed flip through zero or a saturation error therefore shows a few cycles after the press, once the synchroniser has passed the press through. Because position errors only appear on a frame tick, the bench checks pos_x after each tick. A wrong clamp or a wrong border decision shows on the tick that hits the border: pos_x lands off the bound, or speed stays nonzero. Exact landings on a bound are checked separately so that they are not mistaken for hits.

// File: rtl/motion_pkg.sv
// Shared constants for the inertial motion controller.
package motion_pkg;
    localparam int unsigned SCREEN_W  = 640;
    localparam logic        DIR_RIGHT = 1'b1;
    localparam logic        DIR_LEFT  = 1'b0;
endpackage

// File: rtl/press_detect.sv
// Synchronises one active-low button level and emits a one-cycle press
// pulse on its high-to-low transition.
// Assumes the input is already debounced; reset treats the button as released.
module press_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    output logic press
);
    // chain[SYNC_STAGES-1] is the synchronised level, chain[SYNC_STAGES] its previous value
    logic [SYNC_STAGES:0] chain;

    // shift the raw level through the synchroniser and history stage
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[SYNC_STAGES-1:0], btn_n};
    end

    assign press = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];

    // R2: a press is a single-cycle pulse
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        press |=> !press);
endmodule

// File: rtl/velocity_unit.sv
// Holds speed magnitude and direction bit; applies one unit of acceleration
// per press and clears speed on a border hit.
// Assumes MAX_SPEED >= 1 and that press inputs are single-cycle pulses.
module velocity_unit
    import motion_pkg::*;
#(
    parameter int MAX_SPEED = 7,
    parameter int SPW       = $clog2(MAX_SPEED + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           press_l,
    input  logic           press_r,
    input  logic           border_hit,
    output logic [SPW-1:0] speed,
    output logic           dir
);
    localparam logic [SPW-1:0] SPD_MAX = SPW'(MAX_SPEED);

    logic           one_press;
    logic           toward;
    logic [SPW-1:0] spd_n;
    logic           dir_n;

    assign one_press = press_l ^ press_r;
    assign toward    = press_r ? DIR_RIGHT : DIR_LEFT;

    // next velocity: border clear wins, then a single uncancelled press
    always_comb begin
        spd_n = speed;
        dir_n = dir;
        if (border_hit) begin
            spd_n = '0;
        end else if (one_press) begin
            if (dir == toward) begin
                spd_n = (speed == SPD_MAX) ? SPD_MAX : speed + 1'b1;
            end else if (speed == '0) begin
                spd_n = SPW'(1);
                dir_n = toward;
            end else begin
                spd_n = speed - 1'b1;
            end
        end
    end

    // velocity register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed <= '0;
            dir   <= DIR_LEFT;
        end else begin
            speed <= spd_n;
            dir   <= dir_n;
        end
    end

    assert_speed_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        speed <= SPD_MAX);
    assert_hit_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        border_hit |=> speed == '0);
    assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!one_press && !border_hit) |=> ($stable(speed) && $stable(dir)));
    assert_zero_cross_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (one_press && !border_hit && speed == '0 && dir != toward) |=> (speed == SPW'(1) && $changed(dir)));
endmodule

// File: rtl/position_unit.sv
// Advances x by the signed velocity on each frame tick and clamps it to
// [X_MIN, X_MAX], flagging a border hit when a step overshoots.
// Assumes X_MAX + speed fits in XW+1 bits.
module position_unit
    import motion_pkg::*;
#(
    parameter int X_MIN = 8,
    parameter int X_MAX = 599,
    parameter int XW    = 10,
    parameter int SPW   = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [SPW-1:0] speed,
    input  logic           dir,
    output logic [XW-1:0]  pos_x,
    output logic           border_hit
);
    localparam logic [XW:0]   LO     = (XW + 1)'(X_MIN);
    localparam logic [XW:0]   HI     = (XW + 1)'(X_MAX);
    localparam logic [XW-1:0] CENTRE = XW'((X_MIN + X_MAX) / 2);

    logic [XW:0]   up_sum;
    logic [XW:0]   lo_need;
    logic          over;
    logic [XW-1:0] x_n;

    assign up_sum  = {1'b0, pos_x} + {{(XW + 1 - SPW){1'b0}}, speed};
    assign lo_need = LO + {{(XW + 1 - SPW){1'b0}}, speed};

    // candidate next position with clamping at either bound
    always_comb begin
        over = 1'b0;
        x_n  = pos_x;
        if (dir == DIR_RIGHT) begin
            if (up_sum > HI) begin
                over = 1'b1;
                x_n  = HI[XW-1:0];
            end else begin
                x_n = up_sum[XW-1:0];
            end
        end else begin
            if ({1'b0, pos_x} < lo_need) begin
                over = 1'b1;
                x_n  = LO[XW-1:0];
            end else begin
                x_n = pos_x - XW'(speed);
            end
        end
    end

    assign border_hit = tick & over;

    // position register, updated once per frame tick
    always_ff @(posedge clk) begin
        if (!rst_n)    pos_x <= CENTRE;
        else if (tick) pos_x <= x_n;
    end

    assert_pos_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, pos_x} >= LO) && ({1'b0, pos_x} <= HI));
    assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pos_x));
    assert_hit_on_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        border_hit |=> ({1'b0, pos_x} == LO || {1'b0, pos_x} == HI));
endmodule

// File: rtl/inertial_motion_ctrl.sv
// Top level: two press detectors feed the velocity unit; the position unit
// steps x per frame tick and reports border hits back to the velocity unit.
// Assumes debounced active-low buttons and a single-cycle frame_tick.
module inertial_motion_ctrl
    import motion_pkg::*;
#(
    parameter int MARGIN    = 8,
    parameter int SPRITE_W  = 32,
    parameter int MAX_SPEED = 7
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             btn_left_n,
    input  logic                             btn_right_n,
    input  logic                             frame_tick,
    output logic [$clog2(SCREEN_W)-1:0]      pos_x,
    output logic [$clog2(MAX_SPEED+1)-1:0]   speed,
    output logic                             dir_right
);
    localparam int XW    = $clog2(SCREEN_W);
    localparam int SPW   = $clog2(MAX_SPEED + 1);
    localparam int X_MIN = MARGIN;
    localparam int X_MAX = SCREEN_W - 1 - MARGIN - SPRITE_W;
    localparam int NBTN  = 2;

    logic [NBTN-1:0] btn_n;
    logic [NBTN-1:0] press;
    logic            border_hit;

    assign btn_n = {btn_right_n, btn_left_n};

    for (genvar i = 0; i < NBTN; i++) begin : g_btn
        press_detect #(.SYNC_STAGES(2)) u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .btn_n (btn_n[i]),
            .press (press[i])
        );
    end

    velocity_unit #(.MAX_SPEED(MAX_SPEED), .SPW(SPW)) u_vel (
        .clk        (clk),
        .rst_n      (rst_n),
        .press_l    (press[0]),
        .press_r    (press[1]),
        .border_hit (border_hit),
        .speed      (speed),
        .dir        (dir_right)
    );

    position_unit #(.X_MIN(X_MIN), .X_MAX(X_MAX), .XW(XW), .SPW(SPW)) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (frame_tick),
        .speed      (speed),
        .dir        (dir_right),
        .pos_x      (pos_x),
        .border_hit (border_hit)
    );
endmodule

// File: tb/inertial_motion_ctrl_test.sv
// Directed bench for inertial_motion_ctrl, one task per scenario.
module inertial_motion_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_left_n = 1'b1;
    logic       btn_right_n = 1'b1;
    logic       frame_tick = 1'b0;
    logic [9:0] pos_x;
    logic [2:0] speed;
    logic       dir_right;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    inertial_motion_ctrl uut (
        .clk(clk), .rst_n(rst_n), .btn_left_n(btn_left_n), .btn_right_n(btn_right_n),
        .frame_tick(frame_tick), .pos_x(pos_x), .speed(speed), .dir_right(dir_right)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_state(input string req, input int x, input int s, input int d);
        check({req, " pos_x"}, int'(pos_x), x);
        check({req, " speed"}, int'(speed), s);
        check({req, " dir_right"}, int'(dir_right), d);
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic press(input bit l, input bit r);
        @(negedge clk);
        btn_left_n  = ~l;
        btn_right_n = ~r;
        repeat (6) @(negedge clk);
        btn_left_n  = 1'b1;
        btn_right_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) frame_tick = 1'b1;
            @(negedge clk) frame_tick = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic t_reset_R1();
        do_reset();
        check_state("R1", 303, 0, 0);
    endtask

    task automatic t_hold_R2();
        @(negedge clk) btn_left_n = 1'b0;
        repeat (20) @(negedge clk);
        check("R2 held", int'(speed), 1);
        btn_left_n = 1'b1;
        repeat (10) @(negedge clk);
        check_state("R2 released", 303, 1, 0);
    endtask

    task automatic t_tick_R8();
        repeat (50) @(negedge clk);
        check("R8 no tick", int'(pos_x), 303);
        tick(1);
        check("R8 left step", int'(pos_x), 302);
    endtask

    task automatic t_reverse_R4_R5();
        press(1'b0, 1'b1);
        check_state("R4", 302, 0, 0);
        press(1'b0, 1'b1);
        check_state("R5", 302, 1, 1);
        tick(1);
        check("R8 right step", int'(pos_x), 303);
    endtask

    task automatic t_accel_R3();
        press(1'b0, 1'b1);
        press(1'b0, 1'b1);
        check_state("R3", 303, 3, 1);
        tick(1);
        check("R8 step by 3", int'(pos_x), 306);
    endtask

    task automatic t_saturate_R6();
        for (int i = 0; i < 6; i++) press(1'b0, 1'b1);
        check_state("R6", 306, 7, 1);
        tick(1);
        check("R6 step by 7", int'(pos_x), 313);
    endtask

    task automatic t_cancel_R7();
        press(1'b1, 1'b1);
        check_state("R7", 313, 7, 1);
    endtask

    task automatic t_right_clamp_R9();
        tick(40);
        check_state("R9 before border", 593, 7, 1);
        tick(1);
        check_state("R9 right clamp", 599, 0, 1);
        tick(1);
        check("R9 stays", int'(pos_x), 599);
    endtask

    task automatic t_left_exact_R10();
        do_reset();
        for (int i = 0; i < 5; i++) press(1'b1, 1'b0);
        check_state("R3 left accel", 303, 5, 0);
        tick(59);
        check_state("R10 exact landing", 8, 5, 0);
        tick(1);
        check_state("R9 left clamp", 8, 0, 0);
    endtask

    initial begin
        t_reset_R1();
        t_hold_R2();
        t_tick_R8();
        t_reverse_R4_R5();
        t_accel_R3();
        t_saturate_R6();
        t_cancel_R7();
        t_right_clamp_R9();
        t_left_exact_R10();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule